// File: doc/BRIEF.md
# Prioritised Nesting Interrupt Controller

This block gathers interrupt requests for a pipelined processor core. A single software-exception strobe and a set of hardware request lines are captured in a per-source pending register, filtered by a per-source enable register, and arbitrated by fixed priority. The lowest index is the most urgent, and index 0 is the exception. The winner is presented to the instruction sequencer as an offer that carries the source index, the handler address taken from a programmable vector table, and a pipeline-control flag. The flag tells the sequencer either to flush everything in flight (exception) or to let in-flight work retire before entering the handler (hardware interrupt).

The offer uses a valid/ready handshake. The sequencer applies back-pressure by holding `irq_ready` low. While it does, `irq_valid`, `irq_index`, `irq_vector` and `irq_abort` keep their values, even if a more urgent source arrives meanwhile. The offer is consumed in the cycle where both `irq_valid` and `irq_ready` are high. On that edge the source's in-service bit is set, and an edge-type pending bit is cleared. A one-cycle `rti` pulse from the sequencer retires the most urgent in-service source.

Software reaches the block through a plain register port. Writes take effect on the clock edge, and reads are combinational. Register selection uses `cfg_addr`. When bit 4 is 1, bits 3:0 select vector table entry i, which holds the handler address. When bit 4 is 0, the low bits select a control register:
- 0: pending
- 1: enable
- 2: sensitivity of the programmable lines
- 3: control, where bit 0 set means nested mode
- 4: in-service (read only)

Source kinds are fixed at elaboration by a parameter. With the default setting, sources 0, 5, 6 and 7 are edge type and sources 8 to 15 are level type. Sources 1 to 4 are programmable.

Top module: `nest_intc`

## Requirements
- R1: After reset, `irq_valid` is 0. The pending, enable, sensitivity and in-service registers read 0, and the control register reads 1 (nested mode).
- R2: An edge-type source sets its pending bit on a rising edge of its line, including a one-cycle pulse. The bit stays set after the line falls and is cleared when its offer is accepted. With the source enabled and nothing in service, `irq_valid` rises on the second clock edge after the line rises.
- R3: A level-type pending bit equals the line as sampled on the previous clock edge. Acceptance does not clear it, and software writes to it have no effect.
- R4: Sources 1 to 4 take their kind from sensitivity register bits 0 to 3 (bit i-1 for source i), where 1 selects edge and 0 selects level. All other sources have a fixed kind.
- R5: Writing the pending register loads the edge-type bits, so software can raise or clear an edge-type source.
- R6: Hardware source i is offered only while enable bit i is 1. The exception (source 0) ignores enable bit 0.
- R7: Among pending, enabled and eligible sources, the one with the lowest index is offered.
- R8: In nested mode, a source is offered while another is in service only if its index is strictly lower than the lowest in-service index.
- R9: In non-nested mode (control bit 0 = 0), no hardware source is offered while anything is in service. The exception is still offered unless it is itself in service.
- R10: While `irq_valid` is 1 and `irq_ready` is 0, the offer stays asserted and unchanged. Acceptance sets the in-service bit of the offered index.
- R11: `irq_abort` is 1 for an offer of index 0 (flush the pipeline) and 0 for a hardware offer (drain the pipeline).
- R12: An `rti` pulse clears the in-service bit with the lowest index, and only that bit.
- R13: `irq_vector` equals vector table entry `irq_index`. Entry i is written at address 16+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Software exception strobe (source 0, edge) |
| hw_irq | input | 15 | Hardware request lines, bit i is source i (1..15) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq_valid | output | 1 | Offer to the sequencer is valid |
| irq_ready | input | 1 | Sequencer accepts the offer |
| irq_index | output | 4 | Offered source index |
| irq_vector | output | 32 | Handler address of the offered source |
| irq_abort | output | 1 | 1: flush the pipeline, 0: drain it |
| rti | input | 1 | Return from the current handler |

## Verification
The hardest state to reach is a stack of handlers several levels deep with a blocked source waiting beneath them. Reaching it needs the pending register, the handshake and `rti` pulses interleaved in a chosen order. The bench raises edge sources one at a time through software writes to the pending register and accepts each offer before raising the next. It then checks that a source of middling priority stays blocked until a return exposes a less urgent handler. A second scenario holds `irq_ready` low while a more urgent source arrives, to confirm the held offer does not change.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SEL_PEND  = 3'd0,
    SEL_EN    = 3'd1,
    SEL_SENSE = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_INSVC = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_latch.sv
module intc_latch #(
  parameter int           N          = 16,
  parameter int           PROG_BASE  = 1,
  parameter int           PROG_N     = 4,
  parameter logic [N-1:0] FIXED_EDGE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      raw,
  input  logic [PROG_N-1:0] prog_sense,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_val,
  input  logic [N-1:0]      clr,
  output logic [N-1:0]      pend,
  output logic [N-1:0]      is_edge
);
  logic [N-1:0] prev;
  logic [N-1:0] evt;
  logic         past_ok;

  assign evt = raw & ~prev;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (i >= PROG_BASE && i < PROG_BASE + PROG_N) begin : g_prog
      assign is_edge[i] = prog_sense[i-PROG_BASE];
    end else begin : g_fixed
      assign is_edge[i] = FIXED_EDGE[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[i] <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        prev[i] <= raw[i];
        if (is_edge[i]) begin
          if (evt[i])        pend[i] <= 1'b1;
          else if (clr[i])   pend[i] <= 1'b0;
          else if (wr_en)    pend[i] <= wr_val[i];
        end else begin
          pend[i] <= raw[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((pend ^ $past(raw)) & ~$past(is_edge)) == '0)); // R3

  AST_EDGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend & $past(clr & is_edge & ~evt)) == '0)); // R2

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_en) |-> ((~pend & $past(pend & is_edge & ~clr)) == '0)); // R2
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N      = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int VEC_W  = 32,
  parameter int PROG_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N-1:0]      pend_in,
  input  logic [N-1:0]      insvc_in,
  output logic [N-1:0]      en_mask,
  output logic [PROG_N-1:0] sense,
  output logic              nest_en,
  output logic              pend_wr,
  output logic [N-1:0]      pend_wval,
  input  logic [IDX_W-1:0]  vec_sel,
  output logic [VEC_W-1:0]  vec_out
);
  logic [VEC_W-1:0] tab [N];
  logic             is_tab;
  logic [IDX_W-1:0] tab_idx;
  reg_sel_e         sel;

  assign is_tab  = addr[ADDR_W-1];
  assign tab_idx = addr[IDX_W-1:0];
  assign sel     = reg_sel_e'(addr[2:0]);

  assign pend_wr   = wr && !is_tab && (addr[ADDR_W-2:0] == (ADDR_W-1)'(SEL_PEND));
  assign pend_wval = wdata[N-1:0];
  assign vec_out   = tab[vec_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0;
      sense   <= '0;
      nest_en <= 1'b1;
      for (int i = 0; i < N; i++) tab[i] <= '0;
    end else if (wr) begin
      if (is_tab) begin
        tab[tab_idx] <= wdata[VEC_W-1:0];
      end else if (addr[ADDR_W-2:3] == '0) begin
        case (sel)
          SEL_EN:    en_mask <= wdata[N-1:0];
          SEL_SENSE: sense   <= wdata[PROG_N-1:0];
          SEL_CTRL:  nest_en <= wdata[0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_tab) begin
      rdata = DATA_W'(tab[tab_idx]);
    end else if (addr[ADDR_W-2:3] == '0) begin
      case (sel)
        SEL_PEND:  rdata = DATA_W'(pend_in);
        SEL_EN:    rdata = DATA_W'(en_mask);
        SEL_SENSE: rdata = DATA_W'(sense);
        SEL_CTRL:  rdata = DATA_W'(nest_en);
        SEL_INSVC: rdata = DATA_W'(insvc_in);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nest_intc.sv
module nest_intc #(
  parameter int                  NUM_SRC    = 16,
  parameter int                  VEC_W      = 32,
  parameter int                  DATA_W     = 32,
  parameter int                  PROG_BASE  = 1,
  parameter int                  PROG_N     = 4,
  parameter logic [NUM_SRC-1:0]  FIXED_EDGE = 16'h00E1,
  localparam int                 IDX_W      = $clog2(NUM_SRC),
  localparam int                 ADDR_W     = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [NUM_SRC-1:1] hw_irq,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [IDX_W-1:0]   irq_index,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               irq_abort,
  input  logic               rti
);
  logic [NUM_SRC-1:0] raw, pend, is_edge, en_mask, pend_wval;
  logic [NUM_SRC-1:0] insvc, eligible, enabled, clr_vec, acc_oh, act_oh;
  logic [PROG_N-1:0]  sense;
  logic               nest_en, pend_wr;
  logic               act_any, cand_vld, accept;
  logic [IDX_W-1:0]   act_idx, cand_idx;
  logic               offer_vld;
  logic [IDX_W-1:0]   offer_idx;

  assign raw = {hw_irq, exc_req};

  intc_latch #(
    .N(NUM_SRC), .PROG_BASE(PROG_BASE), .PROG_N(PROG_N), .FIXED_EDGE(FIXED_EDGE)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .raw(raw), .prog_sense(sense),
    .wr_en(pend_wr), .wr_val(pend_wval), .clr(clr_vec),
    .pend(pend), .is_edge(is_edge)
  );

  intc_regs #(
    .N(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VEC_W(VEC_W), .PROG_N(PROG_N)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .pend_in(pend), .insvc_in(insvc), .en_mask(en_mask),
    .sense(sense), .nest_en(nest_en), .pend_wr(pend_wr), .pend_wval(pend_wval),
    .vec_sel(offer_idx), .vec_out(irq_vector)
  );

  intc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_act (
    .req(insvc), .found(act_any), .idx(act_idx)
  );

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!act_any)     eligible[i] = 1'b1;
      else if (nest_en) eligible[i] = (IDX_W'(i) < act_idx);
      else              eligible[i] = (i == 0) && !insvc[0];
    end
  end

  assign enabled = pend & (en_mask | NUM_SRC'(1)) & eligible;

  intc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_cand (
    .req(enabled), .found(cand_vld), .idx(cand_idx)
  );

  assign accept  = offer_vld && irq_ready;
  assign acc_oh  = accept ? (NUM_SRC'(1) << offer_idx) : '0;
  assign act_oh  = (rti && act_any) ? (NUM_SRC'(1) << act_idx) : '0;
  assign clr_vec = acc_oh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_vld <= 1'b0;
      offer_idx <= '0;
      insvc     <= '0;
    end else begin
      insvc <= (insvc & ~act_oh) | acc_oh;
      if (accept) begin
        offer_vld <= 1'b0;
      end else if (!offer_vld && cand_vld) begin
        offer_vld <= 1'b1;
        offer_idx <= cand_idx;
      end
    end
  end

  assign irq_valid = offer_vld;
  assign irq_index = offer_idx;
  assign irq_abort = offer_vld && (offer_idx == '0);

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_index)); // R10

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld && nest_en && act_any |-> cand_idx < act_idx); // R8

  AST_FLAT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld && !nest_en && act_any |-> cand_idx == '0 && !insvc[0]); // R9

  AST_RTI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rti && !accept && act_any |=> $countones(insvc) == $past($countones(insvc)) - 1); // R12

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_vld && cand_idx != '0 |-> en_mask[cand_idx]); // R6

  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> insvc[$past(irq_index)]); // R10
endmodule

// File: tb/nest_intc_tb.sv
module nest_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [15:1] hw_irq = '0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [3:0]  irq_index;
  logic [31:0] irq_vector;
  logic        irq_abort;
  logic        rti = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  nest_intc u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .hw_irq(hw_irq),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_index(irq_index), .irq_vector(irq_vector), .irq_abort(irq_abort),
    .rti(rti)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] vec_of(input int i);
    return 32'hA000_0000 + 32'(i) * 32'h100;
  endfunction

  task automatic wait_offer(input string req, input int exp_idx);
    int n = 0;
    while (!irq_valid && n < 8) begin tick(1); n++; end
    chk({req, " offer valid"}, 32'(irq_valid), 32'd1);
    chk({req, " offer index"}, 32'(irq_index), 32'(exp_idx));
  endtask

  task automatic accept_one();
    irq_ready = 1'b1; tick(1); irq_ready = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1; tick(1); rti = 1'b0;
  endtask

  task automatic chk_insvc(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(5'd4, d);
    chk({req, " in-service"}, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid", 32'(irq_valid), 0);
    rd(5'd0, d); chk("R1 pending", d, 0);
    rd(5'd1, d); chk("R1 enable", d, 0);
    rd(5'd2, d); chk("R1 sense", d, 0);
    rd(5'd3, d); chk("R1 control", d, 1);
    rd(5'd4, d); chk("R1 in-service", d, 0);
  endtask

  task automatic t_setup();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) wr(5'(16 + i), vec_of(i));
    rd(5'd19, d); chk("R13 table readback", d, vec_of(3));
    wr(5'd1, 32'hFFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    hw_irq[5] = 1'b1; tick(1); hw_irq[5] = 1'b0;
    chk("R2 no offer after one edge", 32'(irq_valid), 0);
    tick(1);
    chk("R2 offer on second edge", 32'(irq_valid), 1);
    chk("R2 index", 32'(irq_index), 5);
    chk("R13 vector", irq_vector, vec_of(5));
    chk("R11 drain for hw", 32'(irq_abort), 0);
    rd(5'd0, d); chk("R2 pending held after line low", d & 32'h20, 32'h20);
    accept_one();
    rd(5'd0, d); chk("R2 cleared on accept", d & 32'h20, 0);
    chk_insvc("R10 accept sets", 32'h20);
    do_rti();
    chk_insvc("R12 rti pops", 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    hw_irq[9] = 1'b1; tick(1);
    rd(5'd0, d); chk("R3 level follows high", d & 32'h200, 32'h200);
    wait_offer("R3", 9);
    accept_one();
    rd(5'd0, d); chk("R3 not cleared by accept", d & 32'h200, 32'h200);
    wr(5'd0, 32'h0000_0400);
    rd(5'd0, d); chk("R3 write ignored", d & 32'h600, 32'h200);
    hw_irq[9] = 1'b0; tick(1);
    rd(5'd0, d); chk("R3 level follows low", d & 32'h200, 0);
    do_rti();
    tick(3);
    chk("R3 no offer after drop", 32'(irq_valid), 0);
  endtask

  task automatic t_prog_mask();
    logic [31:0] d;
    wr(5'd1, 32'h0);
    wr(5'd2, 32'h2);
    hw_irq[2] = 1'b1; tick(1); hw_irq[2] = 1'b0; tick(1);
    rd(5'd0, d); chk("R4 line2 edge keeps", d & 32'h4, 32'h4);
    wr(5'd0, 32'h0);
    rd(5'd0, d); chk("R5 software clear", d & 32'h4, 0);
    wr(5'd0, 32'h4);
    rd(5'd0, d); chk("R5 software raise", d & 32'h4, 32'h4);
    wr(5'd0, 32'h0);
    wr(5'd2, 32'h0);
    hw_irq[2] = 1'b1; tick(1);
    rd(5'd0, d); chk("R4 line2 level high", d & 32'h4, 32'h4);
    hw_irq[2] = 1'b0; tick(1);
    rd(5'd0, d); chk("R4 line2 level low", d & 32'h4, 0);
    wr(5'd0, 32'h40);
    tick(3);
    chk("R6 masked not offered", 32'(irq_valid), 0);
    wr(5'd1, 32'h40);
    wait_offer("R6 enabled", 6);
    accept_one(); do_rti();
    wr(5'd1, 32'h0);
    exc_req = 1'b1; tick(1); exc_req = 1'b0;
    wait_offer("R6 exception ignores mask", 0);
    chk("R11 abort for exception", 32'(irq_abort), 1);
    chk("R13 exception vector", irq_vector, vec_of(0));
    accept_one(); do_rti();
    wr(5'd1, 32'hFFFF);
  endtask

  task automatic t_prio();
    wr(5'd0, 32'hE0);
    wait_offer("R7 first", 5);
    accept_one(); do_rti();
    wait_offer("R7 second", 6);
    accept_one(); do_rti();
    wait_offer("R7 third", 7);
    accept_one(); do_rti();
    chk_insvc("R7 all retired", 0);
  endtask

  task automatic t_nest();
    wr(5'd0, 32'h80);
    wait_offer("R8 base", 7);
    accept_one();
    wr(5'd0, 32'h20);
    wait_offer("R8 preempt", 5);
    accept_one();
    chk_insvc("R8 two deep", 32'hA0);
    wr(5'd0, 32'h40);
    tick(3);
    chk("R8 lower blocked", 32'(irq_valid), 0);
    do_rti();
    chk_insvc("R12 pops lowest", 32'h80);
    wait_offer("R8 unblocked", 6);
    accept_one();
    do_rti(); do_rti();
    chk_insvc("R8 unwound", 0);
  endtask

  task automatic t_flat();
    wr(5'd3, 32'h0);
    wr(5'd0, 32'h80);
    wait_offer("R9 base", 7);
    accept_one();
    wr(5'd0, 32'h20);
    tick(3);
    chk("R9 higher blocked", 32'(irq_valid), 0);
    exc_req = 1'b1; tick(1); exc_req = 1'b0;
    wait_offer("R9 exception passes", 0);
    accept_one();
    do_rti();
    chk_insvc("R9 after exception rti", 32'h80);
    tick(3);
    chk("R9 still blocked", 32'(irq_valid), 0);
    do_rti();
    wait_offer("R9 released", 5);
    accept_one(); do_rti();
    wr(5'd3, 32'h1);
  endtask

  task automatic t_hold();
    wr(5'd0, 32'h40);
    wait_offer("R10 initial", 6);
    wr(5'd0, 32'h60);
    tick(4);
    chk("R10 held valid", 32'(irq_valid), 1);
    chk("R10 held index", 32'(irq_index), 6);
    chk("R13 held vector", irq_vector, vec_of(6));
    accept_one();
    wait_offer("R10 next after accept", 5);
    accept_one();
    chk_insvc("R10 both in service", 32'h60);
    do_rti(); do_rti();
    chk_insvc("R10 unwound", 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_setup();
    t_edge();
    t_level();
    t_prog_mask();
    t_prio();
    t_nest();
    t_flat();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule